// File: doc/BRIEF.md
# Receive FIFO with Channel-Mode Routing

This block holds the receive side of a serial port's byte buffer. Bytes arrive from a bit deserializer, from a line-break detector, or from the CPU data-register write path. A two-bit channel mode decides whether each byte goes into the receive FIFO, onto the transmit-push path toward a separate transmit FIFO, into both, or nowhere. A CPU read of the data register pops the oldest byte. An empty or gated read returns zero.

A small control register sits inside the block. It has receive enable and receive disable bits, two self-clearing flush bits and two bits that only go to the transmit side. Every byte the FIFO accepts reloads an inactivity counter to four character times. When that counter runs out, a one-cycle timeout event is raised. Occupancy, overflow and timeout outputs go to the interrupt logic next to the block.

Top module: `uart_rx_route_fifo`

## Requirements
- R1: After reset the control readback is 0x34 (bit 2 receive-on, bit 4 transmit-on, bit 5 break-stop set; all others clear), the occupancy is 0, rxEmpty is 1, rxFull is 0 and rdData is 0.
- R2: A serial byte (serValid) goes to the receive FIFO in modes 0 (normal) and 1 (echo). It is presented on txPushValid/txPushData one cycle later in modes 1 and 3 (remote loopback). It goes nowhere in mode 2 (local loopback).
- R3: A CPU data write (cpuWrValid) is presented on the transmit-push path in mode 0 and goes into the receive FIFO in mode 2. In modes 1 and 3 it is dropped.
- R4: A read strobe pops the oldest byte, which appears on rdData in the cycle after the strobe. Bytes leave in arrival order.
- R5: A read strobe on an empty FIFO loads 0 into rdData and leaves the occupancy at 0.
- R6: rxFull is 1 when the occupancy equals DEPTH. A push while full is dropped without disturbing the stored bytes, and ovfEvent pulses for one cycle after it.
- R7: While control bit 2 is clear or bit 3 is set, receive pushes are ignored, and reads return 0 without popping.
- R8: A control write with bit 0 set empties the receive FIFO at that edge. A write with bit 1 set pulses txFlush for one cycle. Bits 0 and 1 always read back as 0, and bits 5:2 take the written value.
- R9: Each byte the FIFO accepts reloads the inactivity counter with 4×charTicks. timeoutEvent pulses for one cycle exactly 4×charTicks cycles after the last accepted push edge, provided no later push has reloaded the counter.
- R10: A serBreak strobe pushes a 0x00 byte into the receive FIFO in any channel mode.
- R11: At most one receive push happens per cycle. A serial byte or a loopback CPU write takes precedence, and a break that coincides with either is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanMode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| serValid | input | 1 | Received serial byte strobe |
| serByte | input | 8 | Received serial byte |
| serBreak | input | 1 | Line break detected strobe |
| cpuWrValid | input | 1 | CPU data-register write strobe |
| cpuWrData | input | 8 | CPU data-register write byte |
| cpuRdValid | input | 1 | CPU data-register read strobe |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 6 | Control register write value |
| charTicks | input | TICK_W | Clock cycles per character time |
| ctrlQ | output | 6 | Control register readback |
| txPushValid | output | 1 | Byte offered to the transmit FIFO |
| txPushData | output | 8 | Byte offered to the transmit FIFO |
| txFlush | output | 1 | Transmit FIFO flush pulse |
| rdData | output | 8 | Data-register read result |
| rxCount | output | clog2(DEPTH)+1 | Receive FIFO occupancy |
| rxEmpty | output | 1 | Receive FIFO empty |
| rxFull | output | 1 | Receive FIFO full |
| ovfEvent | output | 1 | Receive overflow pulse |
| timeoutEvent | output | 1 | Inactivity timeout pulse |

## Verification
The bench builds the block with DEPTH=4 and TICK_W=4, and runs it with a character time of 3 cycles. The shallow FIFO puts the full and overflow boundary, and the pointer wrap, within five pushes. The short character time gives a 12-cycle timeout window, so the bench can check the expiry on the exact cycle and can show that a reload pushes the expiry back.

// File: rtl/uart_rxr_pkg.sv
package uart_rxr_pkg;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 6;
  localparam int CB_RX_FLUSH = 0;
  localparam int CB_TX_FLUSH = 1;
  localparam int CB_RX_ON = 2;
  localparam int CB_RX_OFF = 3;
  localparam int CB_TX_ON = 4;
  localparam int CB_BRK_STOP = 5;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 6'h34;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ECHO   = 2'd1,
    MODE_LOCAL  = 2'd2,
    MODE_REMOTE = 2'd3
  } chanMode_t;

  typedef struct packed {
    logic              push;
    logic [BYTE_W-1:0] pushData;
    logic              pop;
    logic              rdReq;
    logic              flush;
  } rxStrobe_t;
endpackage

// File: rtl/uart_rxr_ctrl.sv
module uart_rxr_ctrl
  import uart_rxr_pkg::*;
#(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        chanMode,
  input  logic              serValid,
  input  logic [BYTE_W-1:0] serByte,
  input  logic              serBreak,
  input  logic              cpuWrValid,
  input  logic [BYTE_W-1:0] cpuWrData,
  input  logic              cpuRdValid,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic [TICK_W-1:0] charTicks,
  input  logic              pushAccepted,
  output rxStrobe_t         strobe,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              txPushValid,
  output logic [BYTE_W-1:0] txPushData,
  output logic              txFlush,
  output logic              timeoutEvent
);
  localparam int TMO_W = TICK_W + 2;

  chanMode_t   mode;
  logic        rxOpen, serToRx, serToTx, cpuToRx, cpuToTx;
  logic [TMO_W-1:0] tmoCnt;

  always_comb begin
    mode    = chanMode_t'(chanMode);
    rxOpen  = ctrlQ[CB_RX_ON] & ~ctrlQ[CB_RX_OFF];
    serToRx = serValid & ((mode == MODE_NORMAL) | (mode == MODE_ECHO));
    serToTx = serValid & ((mode == MODE_ECHO) | (mode == MODE_REMOTE));
    cpuToRx = cpuWrValid & (mode == MODE_LOCAL);
    cpuToTx = cpuWrValid & (mode == MODE_NORMAL);
    strobe.push     = rxOpen & (serToRx | cpuToRx | serBreak);
    strobe.pushData = serToRx ? serByte : (cpuToRx ? cpuWrData : '0);
    strobe.pop      = rxOpen & cpuRdValid;
    strobe.rdReq    = cpuRdValid;
    strobe.flush    = ctrlWe & ctrlWdata[CB_RX_FLUSH];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ        <= CTRL_RESET;
      txPushValid  <= 1'b0;
      txPushData   <= '0;
      txFlush      <= 1'b0;
      tmoCnt       <= '0;
      timeoutEvent <= 1'b0;
    end else begin
      if (ctrlWe) ctrlQ <= {ctrlWdata[CTRL_W-1:2], 2'b00};
      txFlush     <= ctrlWe & ctrlWdata[CB_TX_FLUSH];
      txPushValid <= serToTx | cpuToTx;
      txPushData  <= serToTx ? serByte : cpuWrData;
      if (pushAccepted) tmoCnt <= {charTicks, 2'b00};
      else if (tmoCnt != '0) tmoCnt <= tmoCnt - TMO_W'(1);
      timeoutEvent <= !pushAccepted && (tmoCnt == TMO_W'(1));
    end
  end

  // R9: the timeout pulse lasts a single cycle
  a_r9_timeout_pulse: assert property (@(posedge clk) disable iff (!rstN)
    timeoutEvent |=> !timeoutEvent);
  // R9: the pulse only follows the last count of the window
  a_r9_timeout_window: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutEvent) |-> (tmoCnt == '0));
endmodule

// File: rtl/uart_rxr_datapath.sv
module uart_rxr_datapath
  import uart_rxr_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  output logic              pushAccepted,
  output logic [BYTE_W-1:0] rdData,
  output logic [CNT_W-1:0]  rxCount,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic              ovfEvent
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              popOk;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    rxFull       = (rxCount == CNT_W'(DEPTH));
    rxEmpty      = (rxCount == '0);
    pushAccepted = strobe.push & ~rxFull & ~strobe.flush;
    popOk        = strobe.pop & ~rxEmpty;
  end

  always_ff @(posedge clk) begin
    if (pushAccepted) mem[wrPtr] <= strobe.pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      rxCount  <= '0;
      rdData   <= '0;
      ovfEvent <= 1'b0;
    end else begin
      ovfEvent <= strobe.push & rxFull & ~strobe.flush;
      if (strobe.rdReq) rdData <= popOk ? mem[rdPtr] : '0;
      if (strobe.flush) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        rxCount <= '0;
      end else begin
        if (pushAccepted) wrPtr <= nextPtr(wrPtr);
        if (popOk) rdPtr <= nextPtr(rdPtr);
        rxCount <= rxCount + CNT_W'(pushAccepted) - CNT_W'(popOk);
      end
    end
  end

  // R6: occupancy never goes past the depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(DEPTH));
  // R6: an overflow pulse is only seen after a full cycle
  a_r6_ovf_when_full: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvent |-> $past(rxFull));
  // R5: a read of an empty FIFO yields zero
  a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdReq && rxEmpty) |=> (rdData == '0));
  // R8: a receive flush leaves the FIFO empty
  a_r8_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> rxEmpty);
endmodule

// File: rtl/uart_rx_route_fifo.sv
module uart_rx_route_fifo
  import uart_rxr_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TICK_W = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        chanMode,
  input  logic              serValid,
  input  logic [7:0]        serByte,
  input  logic              serBreak,
  input  logic              cpuWrValid,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuRdValid,
  input  logic              ctrlWe,
  input  logic [5:0]        ctrlWdata,
  input  logic [TICK_W-1:0] charTicks,
  output logic [5:0]        ctrlQ,
  output logic              txPushValid,
  output logic [7:0]        txPushData,
  output logic              txFlush,
  output logic [7:0]        rdData,
  output logic [CNT_W-1:0]  rxCount,
  output logic              rxEmpty,
  output logic              rxFull,
  output logic              ovfEvent,
  output logic              timeoutEvent
);
  rxStrobe_t strobe;
  logic      pushAccepted;

  uart_rxr_ctrl #(.TICK_W(TICK_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .chanMode(chanMode),
    .serValid(serValid), .serByte(serByte), .serBreak(serBreak),
    .cpuWrValid(cpuWrValid), .cpuWrData(cpuWrData), .cpuRdValid(cpuRdValid),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .charTicks(charTicks),
    .pushAccepted(pushAccepted), .strobe(strobe), .ctrlQ(ctrlQ),
    .txPushValid(txPushValid), .txPushData(txPushData), .txFlush(txFlush),
    .timeoutEvent(timeoutEvent)
  );

  uart_rxr_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushAccepted(pushAccepted),
    .rdData(rdData), .rxCount(rxCount), .rxEmpty(rxEmpty), .rxFull(rxFull),
    .ovfEvent(ovfEvent)
  );

  // R7: while the receiver is closed the occupancy does not move
  a_r7_closed_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ((!ctrlQ[CB_RX_ON] || ctrlQ[CB_RX_OFF]) && !(ctrlWe && ctrlWdata[CB_RX_FLUSH]))
      |=> $stable(rxCount));
endmodule

// File: tb/uart_rx_route_fifo_tb_top.sv
module uart_rx_route_fifo_tb_top;
  localparam int DEPTH = 4;
  localparam int TICK_W = 4;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] chanMode = '0;
  logic serValid = 0, serBreak = 0, cpuWrValid = 0, cpuRdValid = 0, ctrlWe = 0;
  logic [7:0] serByte = '0, cpuWrData = '0;
  logic [5:0] ctrlWdata = '0;
  logic [TICK_W-1:0] charTicks = 4'd3;
  logic [5:0] ctrlQ;
  logic txPushValid, txFlush, rxEmpty, rxFull, ovfEvent, timeoutEvent;
  logic [7:0] txPushData, rdData;
  logic [CNT_W-1:0] rxCount;

  int nChecks = 0, nFails = 0, cycles = 0;

  uart_rx_route_fifo #(.DEPTH(DEPTH), .TICK_W(TICK_W)) dut_i (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic serPush(input logic [7:0] b);
    serValid = 1; serByte = b; tick(); serValid = 0;
  endtask

  task automatic cpuWrite(input logic [7:0] b);
    cpuWrValid = 1; cpuWrData = b; tick(); cpuWrValid = 0;
  endtask

  task automatic cpuRead();
    cpuRdValid = 1; tick(); cpuRdValid = 0;
  endtask

  task automatic ctrlWrite(input logic [5:0] v);
    ctrlWe = 1; ctrlWdata = v; tick(); ctrlWe = 0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", 32'(ctrlQ), 32'h34);
    chk("R1 count", 32'(rxCount), 0);
    chk("R1 empty", 32'(rxEmpty), 1);
    chk("R1 full", 32'(rxFull), 0);
    chk("R1 rdData", 32'(rdData), 0);
  endtask

  task automatic t_serial_route();
    chanMode = 2'd0; serPush(8'hA1);
    chk("R2 m0 count", 32'(rxCount), 1); chk("R2 m0 tx", 32'(txPushValid), 0);
    chanMode = 2'd1; serPush(8'hB2);
    chk("R2 m1 count", 32'(rxCount), 2); chk("R2 m1 tx", 32'(txPushValid), 1);
    chk("R2 m1 txData", 32'(txPushData), 32'hB2);
    chanMode = 2'd2; serPush(8'hC3);
    chk("R2 m2 count", 32'(rxCount), 2); chk("R2 m2 tx", 32'(txPushValid), 0);
    chanMode = 2'd3; serPush(8'hD4);
    chk("R2 m3 count", 32'(rxCount), 2); chk("R2 m3 tx", 32'(txPushValid), 1);
    chk("R2 m3 txData", 32'(txPushData), 32'hD4);
    chanMode = 2'd0;
    cpuRead(); chk("R4 first", 32'(rdData), 32'hA1);
    cpuRead(); chk("R4 second", 32'(rdData), 32'hB2);
    chk("R4 drained", 32'(rxCount), 0);
  endtask

  task automatic t_cpu_route();
    chanMode = 2'd0; cpuWrite(8'h11);
    chk("R3 m0 tx", 32'(txPushValid), 1); chk("R3 m0 txData", 32'(txPushData), 32'h11);
    chk("R3 m0 count", 32'(rxCount), 0);
    chanMode = 2'd2; cpuWrite(8'h22);
    chk("R3 m2 count", 32'(rxCount), 1); chk("R3 m2 tx", 32'(txPushValid), 0);
    chanMode = 2'd1; cpuWrite(8'h33);
    chk("R3 m1 count", 32'(rxCount), 1); chk("R3 m1 tx", 32'(txPushValid), 0);
    chanMode = 2'd3; cpuWrite(8'h44);
    chk("R3 m3 count", 32'(rxCount), 1); chk("R3 m3 tx", 32'(txPushValid), 0);
    chanMode = 2'd0;
    cpuRead(); chk("R3 loop byte", 32'(rdData), 32'h22);
  endtask

  task automatic t_empty_read();
    cpuRead();
    chk("R5 zero", 32'(rdData), 0);
    chk("R5 count", 32'(rxCount), 0);
  endtask

  task automatic t_overflow();
    chanMode = 2'd0;
    for (int i = 1; i <= 4; i++) serPush(8'(i));
    chk("R6 full", 32'(rxFull), 1); chk("R6 count", 32'(rxCount), 4);
    chk("R6 no ovf yet", 32'(ovfEvent), 0);
    serPush(8'h05);
    chk("R6 ovf pulse", 32'(ovfEvent), 1); chk("R6 count held", 32'(rxCount), 4);
    tick(); chk("R6 ovf ends", 32'(ovfEvent), 0);
    for (int i = 1; i <= 4; i++) begin
      cpuRead(); chk("R6 order", 32'(rdData), i);
    end
    chk("R6 empty", 32'(rxEmpty), 1);
  endtask

  task automatic t_gate();
    serPush(8'h55);
    ctrlWrite(6'h3C);
    serPush(8'h66); chk("R7 off push", 32'(rxCount), 1);
    cpuRead(); chk("R7 off read", 32'(rdData), 0); chk("R7 off nopop", 32'(rxCount), 1);
    ctrlWrite(6'h30);
    serPush(8'h67); chk("R7 noen push", 32'(rxCount), 1);
    ctrlWrite(6'h34);
    cpuRead(); chk("R7 reopen", 32'(rdData), 32'h55);
  endtask

  task automatic t_flush();
    serPush(8'h01); serPush(8'h02);
    ctrlWrite(6'h37);
    chk("R8 count", 32'(rxCount), 0); chk("R8 empty", 32'(rxEmpty), 1);
    chk("R8 txFlush", 32'(txFlush), 1); chk("R8 readback", 32'(ctrlQ), 32'h34);
    tick(); chk("R8 txFlush ends", 32'(txFlush), 0);
    cpuRead(); chk("R8 flushed read", 32'(rdData), 0);
  endtask

  task automatic t_timer();
    idle(20);
    serPush(8'h10);
    for (int i = 1; i <= 11; i++) begin
      tick(); chk("R9 wait", 32'(timeoutEvent), 0);
    end
    tick(); chk("R9 fire", 32'(timeoutEvent), 1);
    tick(); chk("R9 single", 32'(timeoutEvent), 0);
    idle(5);
    serPush(8'h11); idle(6); serPush(8'h12);
    for (int i = 1; i <= 11; i++) begin
      tick(); chk("R9 restart wait", 32'(timeoutEvent), 0);
    end
    tick(); chk("R9 restart fire", 32'(timeoutEvent), 1);
    ctrlWrite(6'h35);
  endtask

  task automatic t_break();
    chanMode = 2'd0; serPush(8'h77);
    chanMode = 2'd2; serBreak = 1; tick(); serBreak = 0;
    chk("R10 count", 32'(rxCount), 2);
    cpuRead(); chk("R10 prior", 32'(rdData), 32'h77);
    cpuRead(); chk("R10 zero byte", 32'(rdData), 0);
    chk("R10 drained", 32'(rxCount), 0);
  endtask

  task automatic t_priority();
    chanMode = 2'd0; serValid = 1; serByte = 8'h88; serBreak = 1; tick();
    serValid = 0; serBreak = 0;
    chk("R11 ser count", 32'(rxCount), 1);
    cpuRead(); chk("R11 ser wins", 32'(rdData), 32'h88);
    chanMode = 2'd2; cpuWrValid = 1; cpuWrData = 8'h99; serBreak = 1; tick();
    cpuWrValid = 0; serBreak = 0;
    chk("R11 cpu count", 32'(rxCount), 1);
    cpuRead(); chk("R11 cpu wins", 32'(rdData), 32'h99);
    chanMode = 2'd0;
  endtask

  initial begin
    idle(3);
    rstN = 1;
    t_reset();
    t_serial_route();
    t_cpu_route();
    t_empty_read();
    t_overflow();
    t_gate();
    t_flush();
    t_timer();
    t_break();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule